// File: doc/BRIEF.md
# SDI Reclocker Control Logic

This block is the digital control and status logic of a multi-rate serial-video reclocker. It runs on the 27 MHz reference clock. It takes in the operator controls and the status of an abstract PLL and rate detector. These controls are a rate-mode code, a forced-bypass request, an active-low mute and a secondary-output mode select. The PLL and rate detector report signal presence, lock and a detected rate class. From these the block produces a lock-detect indicator and a registered SD/HD flag. It also produces a source-select code for each of the two serial outputs.

Each source-select code tells the analog output path which source to drive onto that output: retimed data, raw (unretimed) input data, the recovered clock, or a muted fixed level. The retimer, the PLL and the line drivers sit outside this block. Mute overrides every bypass condition. When the reclocker is not locked to a supported rate, data goes out raw. The secondary output in clock mode has no valid clock to send while bypassed, so it is muted in that case.

Top module: `reclk_ctrl`

## Requirements
- R1: While reset (rst_n low at a clock edge) is applied, lock_det and sd_flag are 0 at the next clock edge.
- R2: lock_det goes high one clock after sig_present, pll_locked and a supported rate are all true while force_bypass is low. It goes low one clock after any of these stops holding.
- R3: With force_bypass high, lock_det is 0, and an unmuted output in data mode selects raw data (code 2).
- R4: With force_bypass low, each unmuted data output selects raw data whenever lock_det is low, and retimed data (code 1) when lock_det is high. Lock_det is low when the signal is absent, the PLL is unlocked, or det_class is 0 (none) or 3 (unsupported).
- R5: rate_sel 01 accepts only det_class 1 (SD). rate_sel 10 accepts only det_class 2 (HD/3G). A mismatching class counts as unsupported: lock_det stays 0 and outputs go raw.
- R6: When mute_n is 0, both pri_sel and sec_sel are 0 (muted), whatever the bypass and lock state.
- R7: With sec_clk_mode high and mute_n high, sec_sel is 3 (recovered clock) while lock_det is high, and 0 (muted) while bypassed. With sec_clk_mode low, sec_sel equals pri_sel.
- R8: sd_flag is lock_det AND (det_class == 1), both taken one clock earlier. It is therefore 0 whenever lock_det was low in the previous cycle.
- R9: rate_sel 00 and 11 both accept det_class 1 and 2. test_mode is 1 exactly when rate_sel is 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rate_sel | input | 2 | Rate mode: 00 auto, 01 SD only, 10 HD/3G only, 11 test (auto) |
| force_bypass | input | 1 | Forces unretimed output and holds lock_det low |
| mute_n | input | 1 | Active-low mute of both serial outputs |
| sec_clk_mode | input | 1 | Secondary output carries clock (1) or data copy (0) |
| sig_present | input | 1 | Input data activity seen by the detector |
| pll_locked | input | 1 | PLL lock indication |
| det_class | input | 2 | Detected rate class: 0 none, 1 SD, 2 HD/3G, 3 unsupported |
| lock_det | output | 1 | Registered lock-detect indicator |
| sd_flag | output | 1 | Registered SD (1) / HD-3G (0) indicator |
| pri_sel | output | 2 | Primary output source: 0 mute, 1 retimed, 2 raw, 3 clock |
| sec_sel | output | 2 | Secondary output source, same encoding |
| test_mode | output | 1 | High while the reserved test code is selected |

## Verification
Two events can land on the same reference edge: release of mute, and acquisition of lock. In that case the selects must move from muted through raw to retimed in clock-accurate steps. The bench releases mute_n in the same cycle that pll_locked rises, with the secondary output in clock mode. It checks that the outputs show raw/muted before the edge and retimed/clock right after it. A full sweep of every input combination, held until settled, also compares the mute-over-bypass priority and the mode-mismatch rules against values the bench computes itself.

// File: rtl/reclk_pkg.sv
// Shared encodings for the reclocker control logic.
// Assumes 2-bit codes for rate mode, detected class and output source.
package reclk_pkg;
    localparam int RATE_W  = 2;
    localparam int CLASS_W = 2;
    localparam int SEL_W   = 2;
    localparam int NUM_OUT = 2;

    typedef enum logic [SEL_W-1:0] {
        SRC_MUTE    = 2'd0,
        SRC_RETIMED = 2'd1,
        SRC_RAW     = 2'd2,
        SRC_CLOCK   = 2'd3
    } src_sel_t;

    localparam logic [CLASS_W-1:0] CLS_NONE  = 2'd0;
    localparam logic [CLASS_W-1:0] CLS_SD    = 2'd1;
    localparam logic [CLASS_W-1:0] CLS_HD    = 2'd2;
    localparam logic [CLASS_W-1:0] CLS_OTHER = 2'd3;

    localparam logic [RATE_W-1:0] MODE_AUTO = 2'd0;
    localparam logic [RATE_W-1:0] MODE_SD   = 2'd1;
    localparam logic [RATE_W-1:0] MODE_HD   = 2'd2;
    localparam logic [RATE_W-1:0] MODE_TEST = 2'd3;
endpackage

// File: rtl/rate_qual.sv
// Decides whether the detected rate class is acceptable under the chosen
// rate mode. Assumes det_class is already synchronous to clk.
module rate_qual
    import reclk_pkg::*;
(
    input  logic [RATE_W-1:0]  rate_sel,
    input  logic [CLASS_W-1:0] det_class,
    output logic               rate_ok,
    output logic               test_mode
);
    logic class_known;

    // Class is one of the two rates the retimer can handle.
    always_comb class_known = (det_class == CLS_SD) || (det_class == CLS_HD);

    // Fixed modes reject the other class (R5); auto and test accept both (R9).
    always_comb begin
        unique case (rate_sel)
            MODE_SD: rate_ok = (det_class == CLS_SD);
            MODE_HD: rate_ok = (det_class == CLS_HD);
            default: rate_ok = class_known;
        endcase
    end

    // Reserved code raises the test indicator (R9).
    always_comb test_mode = (rate_sel == MODE_TEST);

    always_comb begin
        a_fixed_sd_r5: assert (!(rate_sel == MODE_SD && det_class == CLS_HD && rate_ok));
    end
endmodule

// File: rtl/lock_track.sv
// Registers lock-detect and the SD/HD flag. The flag is formed one cycle
// after lock so it is only valid once lock has settled.
module lock_track
    import reclk_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sig_present,
    input  logic               pll_locked,
    input  logic               force_bypass,
    input  logic               rate_ok,
    input  logic [CLASS_W-1:0] det_class,
    output logic               lock_q,
    output logic               sd_q
);
    logic [CLASS_W-1:0] cls_q;

    // Stage 1: lock qualification and class capture (R2, R3, R4).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= 1'b0;
            cls_q  <= CLS_NONE;
        end else begin
            lock_q <= sig_present && pll_locked && !force_bypass && rate_ok;
            cls_q  <= det_class;
        end
    end

    // Stage 2: SD/HD flag, HD while unlocked (R8).
    always_ff @(posedge clk) begin
        if (!rst_n) sd_q <= 1'b0;
        else        sd_q <= lock_q && (cls_q == CLS_SD);
    end

    p_forced_nolock_r3: assert property (@(posedge clk) disable iff (!rst_n)
        force_bypass |=> !lock_q);
    p_sd_after_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sd_q |-> $past(lock_q));
endmodule

// File: rtl/out_route.sv
// Source select for one serial output. CLK_CAPABLE adds the clock mode
// used by the secondary output. Assumes lock is registered upstream.
module out_route
    import reclk_pkg::*;
#(
    parameter bit CLK_CAPABLE = 1'b0
) (
    input  logic     mute_n,
    input  logic     bypass,
    input  logic     clk_mode,
    output src_sel_t sel
);
    generate
        if (CLK_CAPABLE) begin : g_clk
            // Mute first, then clock mode muted when bypassed (R6, R7).
            always_comb begin
                if (!mute_n)       sel = SRC_MUTE;
                else if (clk_mode) sel = bypass ? SRC_MUTE : SRC_CLOCK;
                else               sel = bypass ? SRC_RAW : SRC_RETIMED;
            end
        end else begin : g_data
            // Mute first, then raw versus retimed data (R4, R6).
            logic unused_mode;
            always_comb unused_mode = clk_mode;
            always_comb begin
                if (!mute_n) sel = SRC_MUTE;
                else         sel = bypass ? SRC_RAW : SRC_RETIMED;
            end
        end
    endgenerate
endmodule

// File: rtl/reclk_ctrl.sv
// Top of the reclocker control logic: rate qualification, lock/SD status
// and per-output source selects. Assumes all inputs are synchronous to clk.
module reclk_ctrl
    import reclk_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RATE_W-1:0]  rate_sel,
    input  logic               force_bypass,
    input  logic               mute_n,
    input  logic               sec_clk_mode,
    input  logic               sig_present,
    input  logic               pll_locked,
    input  logic [CLASS_W-1:0] det_class,
    output logic               lock_det,
    output logic               sd_flag,
    output logic [SEL_W-1:0]   pri_sel,
    output logic [SEL_W-1:0]   sec_sel,
    output logic               test_mode
);
    logic     rate_ok;
    logic     lock_q;
    logic     sd_q;
    logic     bypass;
    src_sel_t route_sel [NUM_OUT];

    rate_qual u_qual (
        .rate_sel  (rate_sel),
        .det_class (det_class),
        .rate_ok   (rate_ok),
        .test_mode (test_mode)
    );

    lock_track u_lock (
        .clk          (clk),
        .rst_n        (rst_n),
        .sig_present  (sig_present),
        .pll_locked   (pll_locked),
        .force_bypass (force_bypass),
        .rate_ok      (rate_ok),
        .det_class    (det_class),
        .lock_q       (lock_q),
        .sd_q         (sd_q)
    );

    // Retiming is skipped when forced or when not locked (R3, R4).
    always_comb bypass = force_bypass || !lock_q;

    // One router per output; index 1 is the clock-capable secondary.
    for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
        out_route #(.CLK_CAPABLE(k == 1)) u_route (
            .mute_n   (mute_n),
            .bypass   (bypass),
            .clk_mode (sec_clk_mode),
            .sel      (route_sel[k])
        );
    end

    // Port mapping of status and selects.
    always_comb begin
        lock_det = lock_q;
        sd_flag  = sd_q;
        pri_sel  = route_sel[0];
        sec_sel  = route_sel[1];
    end

    p_mute_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !mute_n |-> (pri_sel == SRC_MUTE && sec_sel == SRC_MUTE));
    p_clock_needs_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_sel == SRC_CLOCK) |-> (lock_det && sec_clk_mode));
    p_retimed_needs_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pri_sel == SRC_RETIMED) |-> (lock_det && !force_bypass));
    p_forced_raw_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (force_bypass && mute_n) |-> (pri_sel == SRC_RAW));
endmodule

// File: tb/sim_reclk_ctrl.sv
module sim_reclk_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] rate_sel = 2'd0;
    logic       force_bypass = 1'b0;
    logic       mute_n = 1'b1;
    logic       sec_clk_mode = 1'b0;
    logic       sig_present = 1'b0;
    logic       pll_locked = 1'b0;
    logic [1:0] det_class = 2'd0;
    logic       lock_det, sd_flag, test_mode;
    logic [1:0] pri_sel, sec_sel;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    reclk_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .force_bypass(force_bypass),
        .mute_n(mute_n), .sec_clk_mode(sec_clk_mode), .sig_present(sig_present),
        .pll_locked(pll_locked), .det_class(det_class), .lock_det(lock_det),
        .sd_flag(sd_flag), .pri_sel(pri_sel), .sec_sel(sec_sel), .test_mode(test_mode)
    );

    task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1: reset holds status low even with lock conditions present.
        sig_present = 1'b1; pll_locked = 1'b1; det_class = 2'd1;
        @(posedge clk); @(negedge clk);
        chk("R1 lock_det", {1'b0, lock_det}, 2'd0);
        chk("R1 sd_flag", {1'b0, sd_flag}, 2'd0);
        chk("R1 pri_sel raw", pri_sel, 2'd2);
        rst_n = 1'b1;
        pll_locked = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);

        // Same-cycle event: mute release together with lock acquisition (R2, R6, R7, R8).
        mute_n = 1'b0; sec_clk_mode = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R6 pri muted", pri_sel, 2'd0);
        chk("R6 sec muted", sec_sel, 2'd0);
        mute_n = 1'b1; pll_locked = 1'b1;
        #1;
        chk("R4 pri raw before edge", pri_sel, 2'd2);
        chk("R7 sec muted before edge", sec_sel, 2'd0);
        @(posedge clk); @(negedge clk);
        chk("R2 lock after one edge", {1'b0, lock_det}, 2'd1);
        chk("R8 sd not yet", {1'b0, sd_flag}, 2'd0);
        chk("R4 pri retimed", pri_sel, 2'd1);
        chk("R7 sec clock", sec_sel, 2'd3);
        @(posedge clk); @(negedge clk);
        chk("R8 sd one edge after lock", {1'b0, sd_flag}, 2'd1);
        pll_locked = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R2 lock drops", {1'b0, lock_det}, 2'd0);
        chk("R8 sd lags lock", {1'b0, sd_flag}, 2'd1);
        chk("R7 sec muted in bypass", sec_sel, 2'd0);
        @(posedge clk); @(negedge clk);
        chk("R8 sd falls to HD", {1'b0, sd_flag}, 2'd0);

        // Exhaustive steady-state sweep (R3, R4, R5, R6, R7, R8, R9).
        for (int i = 0; i < 512; i++) begin
            logic [1:0] rs, cls, e_pri, e_sec;
            logic fb, mn, cm, pr, lk, sup, e_lock, e_sd, byp;
            rs = i[1:0]; fb = i[2]; mn = i[3]; cm = i[4]; pr = i[5]; lk = i[6]; cls = i[8:7];
            rate_sel = rs; force_bypass = fb; mute_n = mn; sec_clk_mode = cm;
            sig_present = pr; pll_locked = lk; det_class = cls;
            repeat (3) @(posedge clk);
            @(negedge clk);
            sup = (cls == 2'd1 && rs != 2'd2) || (cls == 2'd2 && rs != 2'd1);
            e_lock = pr && lk && !fb && sup;
            e_sd = e_lock && (cls == 2'd1);
            byp = fb || !e_lock;
            e_pri = !mn ? 2'd0 : (byp ? 2'd2 : 2'd1);
            e_sec = !mn ? 2'd0 : (cm ? (byp ? 2'd0 : 2'd3) : e_pri);
            chk("R5 sweep lock_det", {1'b0, lock_det}, {1'b0, e_lock});
            chk("R8 sweep sd_flag", {1'b0, sd_flag}, {1'b0, e_sd});
            chk("R3 R4 R6 sweep pri_sel", pri_sel, e_pri);
            chk("R7 sweep sec_sel", sec_sel, e_sec);
            chk("R9 sweep test_mode", {1'b0, test_mode}, {1'b0, (rs == 2'd3)});
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule